// File: doc/BRIEF.md
# Audio Soft-Mute Controller

This block sits between a serial audio receiver and the downstream filter chain and attenuates a stereo stream of 24-bit two's-complement samples when muting is requested. Both channels share one gain. The gain is held as an unsigned fraction in which 32768 means unity. It changes only when a once-per-sample-period `frame_tick` pulse arrives, so the whole gain trajectory is counted in sample periods rather than clock cycles.

Muting can be requested in two ways. One is an asynchronous active-low pin, which the block resamples with two flops. The other is a clock-loss flag raised by the receiver, which is already in the block's clock domain. The path taken depends on whether audio is flowing when the request is first seen. With audio flowing, the gain falls in a long linear ramp. Without audio, the gain holds and then drops to zero in one step after a short delay. Removing the request restores unity at once.

Samples enter and leave on valid/ready handshakes. The output stage is a single register. An input is accepted when `in_valid` is high and `in_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged.

Top module: `audio_mute_ctrl`

## Requirements
- R1: A mute request is present when the resynchronised `mute_n` is 0 or `clk_lost` is 1. The gain and `muted` change only in cycles where `frame_tick` is 1.
- R2: In the first tick that sees a request, if the block is playing and `audio_active` is 1, a ramp starts. After the k-th ramp tick (k = 1..944) the gain is 32768 - floor(k*32768/944). It is exactly 0 at tick 944, and `muted` rises with that tick.
- R3: In the first tick that sees a request, if the block is playing and `audio_active` is 0, the gain stays at 32768 for ticks 1 to 3. It becomes 0 at tick 4, and `muted` rises with that tick.
- R4: Any tick that sees no request sets the gain to 32768 and clears `muted`, whatever the block was doing. This holds even when the same tick would otherwise have finished a ramp or a delayed step.
- R5: `clk_lost` = 1 produces the same ramp and release behaviour as `mute_n` = 0.
- R6: Each accepted sample is multiplied by the gain current in its accept cycle and divided by 32768, rounding toward zero. At unity the output equals the input, including -8388608.
- R7: `in_ready` = !`out_valid` || `out_ready`. Each accepted input yields exactly one output on the following clock. The output holds steady while it is stalled.
- R8: After reset the gain is unity, `muted` is 0, `out_valid` is 0 and `in_ready` is 1.
- R9: A change on `mute_n` is ignored by a tick sampled on the second clock edge after the change. A tick sampled on the third or a later edge sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mute_n | input | 1 | Asynchronous mute pin, 0 requests mute |
| clk_lost | input | 1 | Bit clock lost, 1 requests mute |
| audio_active | input | 1 | 1 while valid audio is arriving |
| frame_tick | input | 1 | One-cycle pulse per sample period |
| in_valid | input | 1 | Input sample pair valid |
| in_ready | output | 1 | Block can accept a sample pair |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output sample pair valid |
| out_ready | input | 1 | Downstream accepts output |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | 1 while the gain is zero after a mute |

## Verification
The most delicate coincidence is a release arriving on the very tick that would finish a mute. That tick could be the 944th ramp step or the 4th delayed step. The bench provokes it by advancing a ramp to 943 ticks, raising the pin three cycles before the next tick, and then probing the gain. A correct block returns to unity with `muted` low, not to zero. The second coincidence is a sample accepted in the same cycle as a tick. That sample must be scaled with the gain from before the tick, and the following sample with the gain from after it.

// File: rtl/amc_pkg.sv
package amc_pkg;
  // Gain sequencer phases
  typedef enum logic [1:0] {
    ST_PLAY  = 2'd0,  // unity gain
    ST_RAMP  = 2'd1,  // linear fade in progress
    ST_WAIT  = 2'd2,  // idle-stream delay before hard step
    ST_MUTED = 2'd3   // gain held at zero
  } mute_state_t;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/amc_sync.sv
module amc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/amc_gain_seq.sv
module amc_gain_seq
  import amc_pkg::*;
#(
  parameter int GAIN_W     = 16,
  parameter int RAMP_LEN   = 944,
  parameter int WAIT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req,
  input  logic              audio_active,
  output logic [GAIN_W-1:0] gain,
  output logic              muted
);
  localparam int UNITY_I = 1 << (GAIN_W - 1);
  localparam int Q_I     = UNITY_I / RAMP_LEN;
  localparam int RM_I    = UNITY_I % RAMP_LEN;
  localparam int EW      = $clog2(2 * RAMP_LEN + 1);
  localparam int CW      = $clog2(WAIT_TICKS + 1);

  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(UNITY_I);
  localparam logic [GAIN_W-1:0] Q_G   = GAIN_W'(Q_I);
  localparam logic [EW-1:0]     RM_E  = EW'(RM_I);
  localparam logic [EW-1:0]     RL_E  = EW'(RAMP_LEN);
  localparam logic [CW-1:0]     WT_C  = CW'(WAIT_TICKS);

  mute_state_t       st_q, st_n;
  logic [GAIN_W-1:0] gain_q, gain_n;
  logic [EW-1:0]     err_q, err_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              muted_q, muted_n;

  // Step sizing: a quotient step plus a distributed remainder, so that
  // the sum of all steps equals unity exactly.
  logic [GAIN_W-1:0] base_g, dec, ramp_g;
  logic [EW-1:0]     base_e, e_sum, e_next;
  logic [CW-1:0]     base_c, cnt_inc;

  always_comb begin
    base_g = (st_q == ST_PLAY) ? UNITY : gain_q;
    base_e = (st_q == ST_PLAY) ? '0 : err_q;
    base_c = (st_q == ST_PLAY) ? '0 : cnt_q;
    e_sum  = base_e + RM_E;
    if (e_sum >= RL_E) begin
      dec    = Q_G + GAIN_W'(1);
      e_next = e_sum - RL_E;
    end else begin
      dec    = Q_G;
      e_next = e_sum;
    end
    ramp_g  = (dec >= base_g) ? '0 : (base_g - dec);
    cnt_inc = base_c + CW'(1);
  end

  always_comb begin
    st_n    = st_q;
    gain_n  = gain_q;
    err_n   = err_q;
    cnt_n   = cnt_q;
    muted_n = muted_q;
    if (tick) begin
      if (!req) begin
        st_n    = ST_PLAY;
        gain_n  = UNITY;
        err_n   = '0;
        cnt_n   = '0;
        muted_n = 1'b0;
      end else begin
        unique case (st_q)
          ST_PLAY, ST_RAMP: begin
            if (st_q == ST_RAMP || audio_active) begin
              gain_n  = ramp_g;
              err_n   = e_next;
              st_n    = (ramp_g == '0) ? ST_MUTED : ST_RAMP;
              muted_n = (ramp_g == '0);
            end else if (cnt_inc >= WT_C) begin
              gain_n  = '0;
              st_n    = ST_MUTED;
              muted_n = 1'b1;
            end else begin
              cnt_n = cnt_inc;
              st_n  = ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (cnt_inc >= WT_C) begin
              gain_n  = '0;
              st_n    = ST_MUTED;
              muted_n = 1'b1;
            end else begin
              cnt_n = cnt_inc;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PLAY;
      gain_q  <= UNITY;
      err_q   <= '0;
      cnt_q   <= '0;
      muted_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      gain_q  <= gain_n;
      err_q   <= err_n;
      cnt_q   <= cnt_n;
      muted_q <= muted_n;
    end
  end

  assign gain  = gain_q;
  assign muted = muted_q;
endmodule

// File: rtl/amc_scale.sv
module amc_scale #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 16
) (
  input  logic [DATA_W-1:0] din,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] dout
);
  localparam int PW   = DATA_W + GAIN_W + 1;
  localparam int FRAC = GAIN_W - 1;

  localparam logic signed [PW-1:0] BIAS  = PW'((1 << FRAC) - 1);
  localparam logic signed [PW-1:0] MAX_V =
    $signed({{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PW-1:0] MIN_V = -MAX_V - PW'(1);

  logic signed [PW-1:0] a_ext, g_ext, prod, adj, shifted;

  always_comb begin
    a_ext   = $signed({{(PW-DATA_W){din[DATA_W-1]}}, din});
    g_ext   = $signed({{(PW-GAIN_W){1'b0}}, gain});
    prod    = a_ext * g_ext;
    // bias negative products so the arithmetic shift truncates toward zero
    adj     = prod[PW-1] ? (prod + BIAS) : prod;
    shifted = adj >>> FRAC;
    if (shifted > MAX_V)      dout = MAX_V[DATA_W-1:0];
    else if (shifted < MIN_V) dout = MIN_V[DATA_W-1:0];
    else                      dout = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/audio_mute_ctrl.sv
module audio_mute_ctrl
  import amc_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int GAIN_W     = 16,
  parameter int RAMP_LEN   = 944,
  parameter int WAIT_TICKS = 4,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_n,
  input  logic              clk_lost,
  input  logic              audio_active,
  input  logic              frame_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              muted
);
  logic              mute_n_s;
  logic              mute_req;
  logic [GAIN_W-1:0] gain_w;
  logic              accept;

  amc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mute_n),
    .q     (mute_n_s)
  );

  assign mute_req = !mute_n_s || clk_lost;

  amc_gain_seq #(
    .GAIN_W     (GAIN_W),
    .RAMP_LEN   (RAMP_LEN),
    .WAIT_TICKS (WAIT_TICKS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (frame_tick),
    .req          (mute_req),
    .audio_active (audio_active),
    .gain         (gain_w),
    .muted        (muted)
  );

  logic [DATA_W-1:0] ch_in  [NUM_CH];
  logic [DATA_W-1:0] ch_out [NUM_CH];
  logic [DATA_W-1:0] ch_q   [NUM_CH];

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    amc_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .din  (ch_in[c]),
      .gain (gain_w),
      .dout (ch_out[c])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ch_q[c] <= '0;
      else if (accept) ch_q[c] <= ch_out[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (in_ready)  out_valid <= in_valid;
  end

  assign out_left  = ch_q[0];
  assign out_right = ch_q[1];
endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              mute_req,
  input logic [GAIN_W-1:0] gain,
  input logic              muted,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << (GAIN_W - 1));

  // R1: no tick, no change of gain or status
  a_r1_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(gain) && $stable(muted)));

  // R2: under a standing request the gain never rises
  a_r2_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && mute_req) |=> (gain <= $past(gain)));

  // R4: a tick without request restores unity and clears status
  a_r4_release_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !mute_req) |=> ((gain == UNITY) && !muted));

  // R6: a sample accepted while muted leaves as silence
  a_r6_muted_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && muted) |=> ((out_left == '0) && (out_right == '0)));

  // R7: a stalled output holds
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_left) && $stable(out_right)));
endmodule

bind audio_mute_ctrl amc_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .mute_req   (mute_req),
  .gain       (gain_w),
  .muted      (muted),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_left   (out_left),
  .out_right  (out_right)
);

// File: tb/test_audio_mute_ctrl.sv
`timescale 1ns/1ps
module test_audio_mute_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mute_n = 1'b1;
  logic        clk_lost = 1'b0;
  logic        audio_active = 1'b1;
  logic        frame_tick = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left;
  logic [23:0] out_right;
  logic        muted;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  audio_mute_ctrl i_audio_mute_ctrl (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .clk_lost(clk_lost),
    .audio_active(audio_active), .frame_tick(frame_tick),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right), .muted(muted)
  );

  localparam longint UNITY = 32768;
  localparam longint PROBE = 64'sd4194304;  // 2^22: output = gain*128

  function automatic longint exp_gain(input int k);
    return UNITY - (longint'(k) * UNITY) / 944;
  endfunction

  function automatic longint exp_scale(input longint x, input longint g);
    return (x * g) / UNITY;  // integer division truncates toward zero
  endfunction

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic send(input longint l, input longint r,
                      output longint ol, output longint orr);
    @(negedge clk);
    in_left  = 24'(l);
    in_right = 24'(r);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ol  = longint'($signed(out_left));
    orr = longint'($signed(out_right));
  endtask

  task automatic probe_gain(input string req, input longint g);
    longint ol, orr;
    send(PROBE, -PROBE, ol, orr);
    check(ol == g * 128 && orr == -g * 128, req, ol, g * 128);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk) mute_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
    check(muted == 1'b0, "R8 muted", muted, 0);
    check(in_ready == 1'b1, "R8 in_ready", in_ready, 1);
    begin
      longint ol, orr;
      send(-64'sd8388608, 64'sd8388607, ol, orr);
      check(ol == -8388608 && orr == 8388607, "R6 unity passthrough", ol, -8388608);
    end
    probe_gain("R8 unity gain", UNITY);
  endtask

  task automatic t_ramp();
    audio_active = 1'b1;
    set_pin(1'b0);
    for (int k = 1; k <= 944; k++) begin
      tick();
      probe_gain("R2 ramp gain", exp_gain(k));
      if (k == 1) begin
        longint ol, orr;
        send(-3, 5, ol, orr);
        check(ol == exp_scale(-3, exp_gain(1)) && orr == exp_scale(5, exp_gain(1)),
              "R6 trunc toward zero", ol, exp_scale(-3, exp_gain(1)));
      end
      if (k == 943) check(muted == 1'b0, "R2 muted low before end", muted, 0);
    end
    check(muted == 1'b1, "R2 muted at 944", muted, 1);
    tick();
    probe_gain("R2 stays zero", 0);
    set_pin(1'b1);
    tick();
    check(muted == 1'b0, "R4 release clears muted", muted, 0);
    probe_gain("R4 release unity", UNITY);
  endtask

  task automatic t_idle();
    audio_active = 1'b0;
    set_pin(1'b0);
    for (int k = 1; k <= 3; k++) begin
      tick();
      probe_gain("R3 hold before step", UNITY);
      check(muted == 1'b0, "R3 muted low", muted, 0);
    end
    tick();
    probe_gain("R3 step to zero", 0);
    check(muted == 1'b1, "R3 muted high", muted, 1);
    set_pin(1'b1);
    tick();
    probe_gain("R4 release after step", UNITY);
    audio_active = 1'b1;
  endtask

  task automatic t_clk_lost();
    @(negedge clk) clk_lost = 1'b1;
    tick();
    probe_gain("R5 clock loss ramps", exp_gain(1));
    tick();
    probe_gain("R5 clock loss step 2", exp_gain(2));
    @(negedge clk) clk_lost = 1'b0;
    tick();
    probe_gain("R5 clock return unity", UNITY);
  endtask

  task automatic t_collide();
    set_pin(1'b0);
    for (int k = 1; k <= 943; k++) tick();
    probe_gain("R2 step 943", exp_gain(943));
    set_pin(1'b1);
    tick();
    check(muted == 1'b0, "R4 release wins final ramp tick", muted, 0);
    probe_gain("R4 release wins final ramp tick", UNITY);
    audio_active = 1'b0;
    set_pin(1'b0);
    for (int k = 1; k <= 3; k++) tick();
    set_pin(1'b1);
    tick();
    check(muted == 1'b0, "R4 release wins delayed step", muted, 0);
    probe_gain("R4 release wins delayed step", UNITY);
    audio_active = 1'b1;
  endtask

  task automatic t_sync();
    // pin falls at a negedge; a tick sampled on the 2nd edge misses it
    @(negedge clk) mute_n = 1'b0;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    probe_gain("R9 early tick ignored", UNITY);
    tick();
    probe_gain("R9 later tick sees pin", exp_gain(1));
    set_pin(1'b1);
    tick();
    probe_gain("R9 restore", UNITY);
  endtask

  task automatic t_stream();
    longint hold;
    @(negedge clk);
    out_ready = 1'b0;
    in_left = 24'd1000; in_right = 24'd2000; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1 && out_left == 24'd1000, "R7 first accepted",
          longint'(out_left), 1000);
    in_left = 24'd7; in_right = 24'd9;
    check(in_ready == 1'b0, "R7 ready low when stalled", in_ready, 0);
    hold = longint'(out_left);
    repeat (3) @(negedge clk);
    check(longint'(out_left) == hold && out_valid, "R7 held while stalled",
          longint'(out_left), hold);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_left == 24'd7 && out_right == 24'd9, "R7 second after drain",
          longint'(out_left), 7);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 one output per input", out_valid, 0);
    // sample accepted together with a tick uses the pre-tick gain
    set_pin(1'b0);
    @(negedge clk);
    in_left = 24'(PROBE); in_right = 24'(PROBE); in_valid = 1'b1; frame_tick = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; frame_tick = 1'b0;
    check(longint'($signed(out_left)) == PROBE, "R7 same-cycle tick uses old gain",
          longint'($signed(out_left)), PROBE);
    probe_gain("R7 next sample uses new gain", exp_gain(1));
    set_pin(1'b1);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ramp();
    t_idle();
    t_clk_lost();
    t_collide();
    t_sync();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule